// File: doc/BRIEF.md
# Super-Column Frame Readout Serializer

This block takes one frame of pixel data out of a pixel matrix and places it on a single serial line. Columns are gathered into super columns, and each super column owns one shift chain. A parallel write port fills an acquisition buffer one pixel at a time. Counting logic upstream can keep writing at any moment.

A frame-latch request copies the whole acquisition buffer into the shift chains in one step. The next frame can then be counted while the current one drains, so there is no dead time. The output stream opens with a 32-bit header: a fixed sync pattern, then a frame number. After the header, the concentrator visits the chains round-robin and takes one bit from each per visit. Each chain therefore shifts once per full round.

The matrix size, the columns per super column and the pixel word width are parameters. The default is 128 rows by 96 columns, in 12 super columns of 8 columns, with 28 bits per pixel (two 14-bit counts).

Top module: `sc_readout_top`

## Requirements
- R1: After reset the block is idle: `busy`, `ser_valid`, `ser_sof`, `done` and `overrun` are low, the frame number is 0, and `ser_data` is low whenever `ser_valid` is low.
- R2: A `frame_latch` high at a clock edge while `busy` is low starts a frame. In the next cycle `ser_valid`, `busy` and `ser_sof` are high. `ser_sof` is high only in the first bit cycle of a frame.
- R3: The first 16 bits of a frame are the sync word 0xA5C3, MSB first. The next 16 bits are the frame number, MSB first. The frame number is 0 for the first frame after reset and rises by 1 for each frame that completes.
- R4: Payload bit k (counted from 0 after the header) comes from super column k mod NUM_SC, and is chain bit k / NUM_SC of that chain. Global column c belongs to super column c / COLS_PER_SC, at local column c mod COLS_PER_SC. A chain sends its pixels in ascending order of row·COLS_PER_SC + local column, and each pixel's word is sent MSB first.
- R5: A frame lasts exactly 32 + NUM_SC·ROWS·COLS_PER_SC·BITS_PER_PIX cycles. `ser_valid` and `busy` stay high for all of those cycles without a gap.
- R6: `done` is high for exactly one cycle, the cycle right after the last frame bit. `busy` is low in that cycle, and a `frame_latch` given in that cycle starts the next frame at once.
- R7: A `frame_latch` high at an edge while `busy` is high is ignored. It raises `overrun` for the following cycle only, and it changes neither the stream in progress nor the frame number.
- R8: Pixel writes (`pix_we` with row and column in range) are accepted at any time and go only to the acquisition buffer. A frame carries the buffer contents from before its latch edge, so a write at that same edge or later appears in the next frame only. Pixels that are not written keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the serial rate is one bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_latch | input | 1 | Request to freeze the acquisition buffer and start a frame |
| pix_we | input | 1 | Pixel write strobe |
| pix_row | input | ROW_W | Row of the pixel being written |
| pix_col | input | COL_W | Global column of the pixel being written |
| pix_val | input | BITS_PER_PIX | Pixel word to store |
| ser_data | output | 1 | Serial frame bit |
| ser_valid | output | 1 | A frame bit is present on `ser_data` |
| ser_sof | output | 1 | First bit of a frame |
| busy | output | 1 | A readout is in progress |
| done | output | 1 | One-cycle pulse after the last frame bit |
| overrun | output | 1 | One-cycle pulse: a latch request was ignored |

## Verification
The bench builds the block with 2 rows, 6 columns, 2 columns per super column and 4-bit pixel words. That gives three chains of 16 bits and an 80-cycle frame. Every bit of a frame can therefore be predicted and compared, including the interleaving across chains and the pixel order inside each chain. The short frame also lets the bench test several timing cases that would take far too many cycles at the full size:
- a latch request while a frame is running;
- pixel writes during a readout and in the latch cycle;
- a new frame started in the `done` cycle.

// File: rtl/scr_pkg.sv
package scr_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HEAD = 2'd1,
      PH_BODY = 2'd2
   } scr_phase_e;

   localparam logic [15:0] SCR_SYNC_DEFAULT = 16'hA5C3;
   localparam int SCR_FCNT_W = 16;
   localparam int SCR_HDR_BITS = 32;
endpackage

// File: rtl/scr_chain.sv
// Acquisition buffer plus frozen shift chain for one super column.
// Pixel p lives in the chain at bit slot (NPIX-1-p), so the chain's MSB is pixel 0's MSB.
module scr_chain #(
   parameter int ROWS = 128,
   parameter int CPS  = 8,
   parameter int BPP  = 28,
   localparam int NPIX  = ROWS * CPS,
   localparam int CBITS = NPIX * BPP,
   localparam int PIX_W = (NPIX > 1) ? $clog2(NPIX) : 1,
   localparam int OFF_W = $clog2(CBITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PIX_W-1:0] wr_pix,
   input  logic [BPP-1:0]   wr_val,
   input  logic             load,
   input  logic             shift,
   output logic             msb
);
   logic [CBITS-1:0] acq_q;
   logic [CBITS-1:0] chain_q;
   logic [OFF_W-1:0] base;

   always_comb base = OFF_W'((NPIX - 1 - int'(wr_pix)) * BPP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acq_q   <= '0;
         chain_q <= '0;
      end else begin
         if (wr_en) acq_q[base +: BPP] <= wr_val;
         if (load)
            chain_q <= acq_q;
         else if (shift)
            chain_q <= {chain_q[CBITS-2:0], 1'b0};
      end
   end

   assign msb = chain_q[CBITS-1];
endmodule

// File: rtl/scr_sequencer.sv
// Frame sequencer: header bit index, round-robin chain select, round count, frame number.
module scr_sequencer
   import scr_pkg::*;
#(
   parameter int NUM_SC = 12,
   parameter int CBITS  = 28672,
   localparam int SC_W  = (NUM_SC > 1) ? $clog2(NUM_SC) : 1,
   localparam int RND_W = $clog2(CBITS),
   localparam int HDR_W = $clog2(SCR_HDR_BITS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  latch_req,
   output scr_phase_e            phase,
   output logic [HDR_W-1:0]      head_idx,
   output logic [SC_W-1:0]       sc_sel,
   output logic [SCR_FCNT_W-1:0] frame_num,
   output logic                  load,
   output logic                  shift,
   output logic                  done,
   output logic                  overrun
);
   scr_phase_e            phase_q;
   logic [HDR_W-1:0]      head_q;
   logic [SC_W-1:0]       sc_q;
   logic [RND_W-1:0]      round_q;
   logic [SCR_FCNT_W-1:0] cnt_q;
   logic                  done_q;
   logic                  ovr_q;
   logic                  last_sc;

   assign last_sc = (sc_q == SC_W'(NUM_SC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         head_q  <= '0;
         sc_q    <= '0;
         round_q <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         ovr_q  <= latch_req && (phase_q != PH_IDLE);
         unique case (phase_q)
            PH_IDLE: begin
               if (latch_req) begin
                  phase_q <= PH_HEAD;
                  head_q  <= '0;
               end
            end
            PH_HEAD: begin
               if (head_q == HDR_W'(SCR_HDR_BITS - 1)) begin
                  phase_q <= PH_BODY;
                  sc_q    <= '0;
                  round_q <= '0;
               end else begin
                  head_q <= head_q + HDR_W'(1);
               end
            end
            PH_BODY: begin
               if (last_sc) begin
                  sc_q <= '0;
                  if (round_q == RND_W'(CBITS - 1)) begin
                     phase_q <= PH_IDLE;
                     done_q  <= 1'b1;
                     cnt_q   <= cnt_q + SCR_FCNT_W'(1);
                  end else begin
                     round_q <= round_q + RND_W'(1);
                  end
               end else begin
                  sc_q <= sc_q + SC_W'(1);
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase     = phase_q;
   assign head_idx  = head_q;
   assign sc_sel    = sc_q;
   assign frame_num = cnt_q;
   assign load      = latch_req && (phase_q == PH_IDLE);
   assign shift     = (phase_q == PH_BODY) && last_sc;
   assign done      = done_q;
   assign overrun   = ovr_q;
endmodule

// File: rtl/sc_readout_top.sv
module sc_readout_top
   import scr_pkg::*;
#(
   parameter int          ROWS         = 128,
   parameter int          COLS         = 96,
   parameter int          COLS_PER_SC  = 8,
   parameter int          BITS_PER_PIX = 28,
   parameter logic [15:0] SYNC_WORD    = SCR_SYNC_DEFAULT,
   localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_latch,
   input  logic                    pix_we,
   input  logic [ROW_W-1:0]        pix_row,
   input  logic [COL_W-1:0]        pix_col,
   input  logic [BITS_PER_PIX-1:0] pix_val,
   output logic                    ser_data,
   output logic                    ser_valid,
   output logic                    ser_sof,
   output logic                    busy,
   output logic                    done,
   output logic                    overrun
);
   localparam int NUM_SC  = COLS / COLS_PER_SC;
   localparam int NPIX_SC = ROWS * COLS_PER_SC;
   localparam int CBITS   = NPIX_SC * BITS_PER_PIX;
   localparam int PIX_W   = (NPIX_SC > 1) ? $clog2(NPIX_SC) : 1;
   localparam int SC_W    = (NUM_SC > 1) ? $clog2(NUM_SC) : 1;
   localparam int HDR_W   = $clog2(SCR_HDR_BITS);

   generate
      if (COLS_PER_SC < 1 || (COLS % COLS_PER_SC) != 0) begin : g_bad_grouping
         $error("COLS must be a whole multiple of COLS_PER_SC");
      end
      if (BITS_PER_PIX < 1 || CBITS < 2) begin : g_bad_chain
         $error("each chain must hold at least two bits");
      end
   endgenerate

   scr_phase_e            phase;
   logic [HDR_W-1:0]      head_idx;
   logic [SC_W-1:0]       sc_sel;
   logic [SCR_FCNT_W-1:0] frame_num;
   logic                  load;
   logic                  shift;
   logic [NUM_SC-1:0]     chain_bit;
   logic [NUM_SC-1:0]     wr_sel;
   logic [PIX_W-1:0]      wr_pix;
   logic                  in_range;
   int                    col_sc;
   int                    col_loc;
   logic [SCR_HDR_BITS-1:0] hdr_word;

   // Write address decode: global column to super column and local column.
   always_comb begin
      col_sc   = int'(pix_col) / COLS_PER_SC;
      col_loc  = int'(pix_col) % COLS_PER_SC;
      wr_pix   = PIX_W'(int'(pix_row) * COLS_PER_SC + col_loc);
      in_range = (int'(pix_row) < ROWS) && (int'(pix_col) < COLS);
   end

   scr_sequencer #(
      .NUM_SC (NUM_SC),
      .CBITS  (CBITS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .latch_req (frame_latch),
      .phase     (phase),
      .head_idx  (head_idx),
      .sc_sel    (sc_sel),
      .frame_num (frame_num),
      .load      (load),
      .shift     (shift),
      .done      (done),
      .overrun   (overrun)
   );

   for (genvar g = 0; g < NUM_SC; g++) begin : g_sc
      assign wr_sel[g] = pix_we && in_range && (col_sc == g);

      scr_chain #(
         .ROWS (ROWS),
         .CPS  (COLS_PER_SC),
         .BPP  (BITS_PER_PIX)
      ) u_chain (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_sel[g]),
         .wr_pix (wr_pix),
         .wr_val (pix_val),
         .load   (load),
         .shift  (shift),
         .msb    (chain_bit[g])
      );
   end

   // Concentrator: header bits, then one bit per chain in fixed rotation.
   assign hdr_word = {SYNC_WORD, frame_num};

   always_comb begin
      unique case (phase)
         PH_HEAD: ser_data = hdr_word[HDR_W'(SCR_HDR_BITS - 1) - head_idx];
         PH_BODY: ser_data = chain_bit[sc_sel];
         default: ser_data = 1'b0;
      endcase
   end

   assign busy      = (phase != PH_IDLE);
   assign ser_valid = busy;
   assign ser_sof   = (phase == PH_HEAD) && (head_idx == '0);
endmodule

// File: rtl/scr_readout_chk.sv
module scr_readout_chk (
   input logic clk,
   input logic rst_n,
   input logic frame_latch,
   input logic ser_data,
   input logic ser_valid,
   input logic ser_sof,
   input logic busy,
   input logic done,
   input logic overrun
);
   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_valid |-> !ser_data);

   p_latch_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_latch && !busy) |=> ser_sof);

   p_sof_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ser_sof |-> ser_valid);

   p_sof_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ser_sof |=> !ser_sof);

   p_done_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(frame_latch && busy));

   p_overrun_keeps_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_latch && busy && !ser_sof) |=> !ser_sof);
endmodule

bind sc_readout_top scr_readout_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_latch (frame_latch),
   .ser_data    (ser_data),
   .ser_valid   (ser_valid),
   .ser_sof     (ser_sof),
   .busy        (busy),
   .done        (done),
   .overrun     (overrun)
);

// File: tb/sc_readout_top_test.sv
module sc_readout_top_test;
   localparam int ROWS  = 2;
   localparam int COLS  = 6;
   localparam int CPS   = 2;
   localparam int BPP   = 4;
   localparam int NSC   = COLS / CPS;
   localparam int CBITS = ROWS * CPS * BPP;
   localparam int FLEN  = 32 + NSC * CBITS;
   localparam logic [15:0] SYNC = 16'hA5C3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_latch = 1'b0;
   logic pix_we = 1'b0;
   logic [0:0] pix_row = '0;
   logic [2:0] pix_col = '0;
   logic [BPP-1:0] pix_val = '0;
   logic ser_data, ser_valid, ser_sof, busy, done, overrun;

   int checks = 0;
   int errors = 0;
   logic [BPP-1:0] model_pix [ROWS][COLS];
   logic [BPP-1:0] snap_pix  [ROWS][COLS];

   always #2.5 clk = ~clk;

   sc_readout_top #(
      .ROWS (ROWS), .COLS (COLS), .COLS_PER_SC (CPS), .BITS_PER_PIX (BPP)
   ) uut (
      .clk (clk), .rst_n (rst_n), .frame_latch (frame_latch),
      .pix_we (pix_we), .pix_row (pix_row), .pix_col (pix_col), .pix_val (pix_val),
      .ser_data (ser_data), .ser_valid (ser_valid), .ser_sof (ser_sof),
      .busy (busy), .done (done), .overrun (overrun)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   function automatic bit exp_bit(input int i, input int fnum);
      int j, r, sc, p, b, row, col;
      if (i < 16) return SYNC[15 - i];
      if (i < 32) return fnum[31 - i];
      j   = i - 32;
      r   = j / NSC;
      sc  = j % NSC;
      p   = r / BPP;
      b   = BPP - 1 - (r % BPP);
      row = p / CPS;
      col = sc * CPS + (p % CPS);
      return snap_pix[row][col][b];
   endfunction

   task automatic write_pixel(input int r, input int c, input int v);
      pix_we  = 1'b1;
      pix_row = r[0:0];
      pix_col = c[2:0];
      pix_val = v[BPP-1:0];
      model_pix[r][c] = v[BPP-1:0];
      @(negedge clk);
      pix_we = 1'b0;
   endtask

   // Called at a negedge in a cycle where busy is low; runs one whole frame.
   // late_at: stream index after which a second latch is raised (R7), -1 none.
   // wr_at: stream index after which pixel (1,5) is written with wr_v (R8), -1 none.
   // wr_latch: write pixel (0,0) with wr_v in the latch cycle (R8).
   task automatic run_frame(input int fnum, input int late_at, input int wr_at,
                            input bit wr_latch, input int wr_v);
      frame_latch = 1'b1;
      foreach (model_pix[r, c]) snap_pix[r][c] = model_pix[r][c];
      if (wr_latch) begin
         pix_we = 1'b1; pix_row = 1'b0; pix_col = 3'd0; pix_val = wr_v[BPP-1:0];
         model_pix[0][0] = wr_v[BPP-1:0];
      end
      @(negedge clk);
      frame_latch = 1'b0;
      pix_we = 1'b0;
      for (int i = 0; i < FLEN; i++) begin
         check(ser_data === exp_bit(i, fnum), (i < 32) ? "R3 header bit" : "R4 payload bit",
               int'(ser_data), int'(exp_bit(i, fnum)));
         check(ser_valid === 1'b1 && busy === 1'b1, "R5 valid/busy in frame",
               int'(ser_valid), 1);
         check(ser_sof === (i == 0), "R2 sof position", int'(ser_sof), int'(i == 0));
         if (i == 0) check(done === 1'b0, "R6 done low at frame start", int'(done), 0);
         if (late_at >= 0 && i == late_at + 1)
            check(overrun === 1'b1, "R7 overrun pulse", int'(overrun), 1);
         else
            check(overrun === 1'b0, "R7 overrun quiet", int'(overrun), 0);
         if (i == late_at) frame_latch = 1'b1;
         if (i == wr_at) begin
            pix_we = 1'b1; pix_row = 1'b1; pix_col = 3'd5; pix_val = wr_v[BPP-1:0];
            model_pix[1][5] = wr_v[BPP-1:0];
         end
         @(negedge clk);
         frame_latch = 1'b0;
         pix_we = 1'b0;
      end
      check(done === 1'b1, "R6 done after last bit", int'(done), 1);
      check(busy === 1'b0 && ser_valid === 1'b0, "R5 frame length", int'(busy), 0);
   endtask

   task automatic t_reset();
      check(busy === 1'b0 && ser_valid === 1'b0 && ser_sof === 1'b0, "R1 idle after reset",
            int'(busy), 0);
      check(done === 1'b0 && overrun === 1'b0, "R1 pulses low after reset", int'(done), 0);
      check(ser_data === 1'b0, "R1 data low when idle", int'(ser_data), 0);
   endtask

   task automatic t_first_frame();
      foreach (model_pix[r, c]) write_pixel(r, c, (r * COLS + c + 3) % 16);
      run_frame(0, -1, -1, 1'b0, 0);
      @(negedge clk);
      check(done === 1'b0, "R6 done single cycle", int'(done), 0);
      check(ser_data === 1'b0, "R1 data low between frames", int'(ser_data), 0);
   endtask

   task automatic t_overrun_and_live_write();
      foreach (model_pix[r, c]) write_pixel(r, c, ~((r * COLS + c + 3) % 16));
      repeat (3) @(negedge clk);
      run_frame(1, 40, 50, 1'b0, 9);
      @(negedge clk);
      check(overrun === 1'b0 && busy === 1'b0, "R7 late latch ignored", int'(busy), 0);
   endtask

   task automatic t_back_to_back();
      // frame 2 shows the live write; the latch is raised inside the done cycle
      run_frame(2, -1, -1, 1'b0, 0);
      run_frame(3, -1, -1, 1'b1, 6);
      @(negedge clk);
      run_frame(4, -1, -1, 1'b0, 0);
      check(model_pix[0][0] === 4'd6, "R8 latch-cycle write in later frame",
            int'(model_pix[0][0]), 6);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
   end

   initial begin
      foreach (model_pix[r, c]) model_pix[r][c] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_frame();
      t_overrun_and_live_write();
      t_back_to_back();
      report();
   end
endmodule